// File: doc/BRIEF.md
# Byte-Packed Shared SPI Word Buffer

This block is the word buffer that sits between one SPI channel and the host side. It holds a transmit queue and a receive queue in one shared pool of 64 bytes. Words from 4 to 32 bits long are pushed and popped whole, one per cycle on each side. Each word is held as consecutive bytes with the least significant byte first. Because storage is counted in bytes, a word near the edge of the space or of the data is handled in part: a push stores only its low bytes and a pop returns only the bytes that exist.

A small mode state machine follows the two direction enables. It has four states:
- MODE_OFF: neither side has capacity.
- MODE_TX_ONLY: the transmit side owns all 64 bytes.
- MODE_RX_ONLY: the receive side owns all 64 bytes.
- MODE_SPLIT: each side owns 32 bytes. Transmit uses bytes 0 to 31 and receive uses bytes 32 to 63.

The state register loads the state named by the enable pair on every clock. Any transition between two states clears both sides. The same clear follows a pulse on `reinit`, which the owner raises when the owning channel changes, when its threshold setting is rewritten, or when the channel is re-enabled.

All inputs are sampled on the rising clock edge. Levels, flags, popped words and error pulses all come from registers. A popped word therefore appears on the read-data output in the cycle after the pop request.

Top module: `spi_byte_fifo`

## Requirements
- R1: With only one enable high, that side accepts up to 64 bytes and then shows full = 1. The disabled side has zero capacity: it shows level 0 with full = 1 and empty = 1, and every push to it raises its overflow pulse.
- R2: With both enables high, each side holds at most 32 bytes. A side with 32 bytes shows full, and a further push raises overflow.
- R3: `word_len` gives the word length in bits, from 4 to 32. A word takes ceil(word_len/8) bytes, stored least significant byte first. A pop returns that many bytes with the first-stored byte in bits 7:0, and the word appears on read-data one cycle after the pop.
- R4: A push that finds fewer free bytes than it needs, but at least one, stores its low-order bytes until the side is full. It drops the rest and raises no overflow.
- R5: A pop that finds fewer stored bytes than it needs, but at least one, returns the stored bytes in the low positions. All upper bits of the returned word are zero.
- R6: The read and write positions wrap modulo the side's current capacity. In split mode, a stream of words longer than 32 bytes in total passing through a side comes back in order and intact.
- R7: Any change of the enable pair, and any `reinit` pulse, sets both levels to 0 at the next edge. A push or pop in that same cycle is dropped without an error pulse, and read-data keeps its value.
- R8: A push and a pop on the same side in the same cycle are both carried out. The pop is limited by the level at the start of the cycle, the push by the free space at the start of the cycle, and the level moves by the net byte count.
- R9: A push to a side whose level equals its capacity stores nothing and raises that side's overflow output for exactly one cycle.
- R10: A pop from a side whose level is 0 raises that side's underflow output for one cycle. It leaves the level and read-data unchanged.
- R11: After reset both levels are 0, empty and full are 1 on both sides, both read-data outputs are 0, and no error pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ena | input | 1 | Transmit buffering enable |
| rx_ena | input | 1 | Receive buffering enable |
| reinit | input | 1 | Clear strobe for owner change, threshold rewrite or re-enable |
| word_len | input | 6 | Word length in bits (4 to 32), shared by both sides |
| tx_push | input | 1 | Push a word onto the transmit side |
| tx_wdata | input | 32 | Word to push on the transmit side |
| tx_pop | input | 1 | Pop a word from the transmit side |
| tx_rdata | output | 32 | Last word popped from the transmit side |
| tx_level | output | 7 | Bytes held on the transmit side |
| tx_full | output | 1 | Transmit level has reached its capacity |
| tx_empty | output | 1 | Transmit level is zero |
| tx_ovf | output | 1 | One-cycle pulse: push found the transmit side full |
| tx_unf | output | 1 | One-cycle pulse: pop found the transmit side empty |
| rx_push | input | 1 | Push a word onto the receive side |
| rx_wdata | input | 32 | Word to push on the receive side |
| rx_pop | input | 1 | Pop a word from the receive side |
| rx_rdata | output | 32 | Last word popped from the receive side |
| rx_level | output | 7 | Bytes held on the receive side |
| rx_full | output | 1 | Receive level has reached its capacity |
| rx_empty | output | 1 | Receive level is zero |
| rx_ovf | output | 1 | One-cycle pulse: push found the receive side full |
| rx_unf | output | 1 | One-cycle pulse: pop found the receive side empty |

## Verification
Errors in the internal state show up at different times.
- A wrong level shows in the same cycle on the level, full and empty outputs, and it makes the next boundary push or pop raise, or fail to raise, an error pulse.
- A corrupted read or write position, or a wrap taken at 64 instead of at the split capacity, stays hidden until a later pop. That pop then returns bytes in the wrong order or from the other side's half, one cycle after it is requested.
- A missed clear shows as a nonzero level on the cycle after the enable change or `reinit` pulse.

The bench therefore pushes words across both halves and across the wrap point, and compares every popped word with a byte-level model.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_TX_ONLY = 2'd1,
        MODE_RX_ONLY = 2'd2,
        MODE_SPLIT   = 2'd3
    } fifo_mode_e;
endpackage

// File: rtl/spi_fifo_mode.sv
module spi_fifo_mode
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_ena,
    input  logic                   rx_ena,
    input  logic                   reinit,
    output fifo_mode_e             mode_q,
    output logic                   clear,
    output logic [$clog2(DEPTH):0] tx_cap,
    output logic [$clog2(DEPTH):0] rx_cap
);
    localparam int LW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    fifo_mode_e mode_d;

    // next state: the enable pair names the target state directly
    always_comb begin
        unique case ({tx_ena, rx_ena})
            2'b00:   mode_d = MODE_OFF;
            2'b10:   mode_d = MODE_TX_ONLY;
            2'b01:   mode_d = MODE_RX_ONLY;
            default: mode_d = MODE_SPLIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    // every transition, and every reinit pulse, empties both sides
    assign clear = reinit || (mode_d != mode_q);

    // outputs: capacity of each side in the current state
    always_comb begin
        unique case (mode_q)
            MODE_OFF: begin
                tx_cap = '0;
                rx_cap = '0;
            end
            MODE_TX_ONLY: begin
                tx_cap = LW'(DEPTH);
                rx_cap = '0;
            end
            MODE_RX_ONLY: begin
                tx_cap = '0;
                rx_cap = LW'(DEPTH);
            end
            default: begin
                tx_cap = LW'(HALF);
                rx_cap = LW'(HALF);
            end
        endcase
    end
endmodule

// File: rtl/spi_fifo_side.sv
module spi_fifo_side #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      clear,
    input  logic [$clog2(DEPTH):0]                    cap,
    input  logic [$clog2(DEPTH)-1:0]                  base,
    input  logic [$clog2(WORD_W/8+1)-1:0]             nbytes,
    input  logic                                      push,
    input  logic [WORD_W-1:0]                         wdata,
    input  logic                                      pop,
    input  logic [WORD_W/8-1:0][7:0]                  rd_bytes,
    output logic [WORD_W/8-1:0][$clog2(DEPTH)-1:0]    rd_addr,
    output logic [WORD_W/8-1:0]                       wr_en,
    output logic [WORD_W/8-1:0][$clog2(DEPTH)-1:0]    wr_addr,
    output logic [WORD_W/8-1:0][7:0]                  wr_byte,
    output logic [$clog2(DEPTH):0]                    level,
    output logic [WORD_W-1:0]                         rdata,
    output logic                                      ovf,
    output logic                                      unf
);
    localparam int LANES = WORD_W / 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = AW + 1;
    localparam int SW    = LW + 1;

    logic [LW-1:0] lvl_q, rd_q;
    logic [SW-1:0] cap_w, lvl_w, rd_w, nb_w, free_w, wp_w;
    logic [SW-1:0] n_store, n_take, rd_nx;
    logic [LANES-1:0][SW-1:0] woff, roff;
    logic push_ok, pop_ok, ovf_d, unf_d;
    logic [WORD_W-1:0] word_d;

    always_comb begin
        cap_w  = SW'(cap);
        lvl_w  = SW'(lvl_q);
        rd_w   = SW'(rd_q);
        nb_w   = SW'(nbytes);
        free_w = cap_w - lvl_w;

        push_ok = push && !clear && (lvl_w < cap_w);
        ovf_d   = push && !clear && !(lvl_w < cap_w);
        pop_ok  = pop && !clear && (lvl_w != '0);
        unf_d   = pop && !clear && (lvl_w == '0);

        n_store = push_ok ? ((nb_w < free_w) ? nb_w : free_w) : '0;
        n_take  = pop_ok  ? ((nb_w < lvl_w)  ? nb_w : lvl_w)  : '0;

        // write position = read position + level, wrapped at capacity
        wp_w = rd_w + lvl_w;
        if (wp_w >= cap_w) wp_w = wp_w - cap_w;
        rd_nx = rd_w + n_take;
        if (rd_nx >= cap_w) rd_nx = rd_nx - cap_w;

        word_d = '0;
        for (int i = 0; i < LANES; i++) begin
            woff[i] = wp_w + SW'(i);
            if (woff[i] >= cap_w) woff[i] = woff[i] - cap_w;
            roff[i] = rd_w + SW'(i);
            if (roff[i] >= cap_w) roff[i] = roff[i] - cap_w;
            wr_addr[i] = AW'(SW'(base) + woff[i]);
            rd_addr[i] = AW'(SW'(base) + roff[i]);
            wr_en[i]   = (SW'(i) < n_store);
            wr_byte[i] = wdata[8*i +: 8];
            if (SW'(i) < n_take) word_d[8*i +: 8] = rd_bytes[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            rd_q  <= '0;
            rdata <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            ovf <= ovf_d;
            unf <= unf_d;
            if (clear) begin
                lvl_q <= '0;
                rd_q  <= '0;
            end else begin
                lvl_q <= LW'(lvl_w + n_store - n_take);
                rd_q  <= LW'(rd_nx);
            end
            if (pop_ok) rdata <= word_d;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tx_ena,
    input  logic                          rx_ena,
    input  logic                          reinit,
    input  logic [$clog2(WORD_W+1)-1:0]   word_len,
    input  logic                          tx_push,
    input  logic [WORD_W-1:0]             tx_wdata,
    input  logic                          tx_pop,
    output logic [WORD_W-1:0]             tx_rdata,
    output logic [$clog2(DEPTH):0]        tx_level,
    output logic                          tx_full,
    output logic                          tx_empty,
    output logic                          tx_ovf,
    output logic                          tx_unf,
    input  logic                          rx_push,
    input  logic [WORD_W-1:0]             rx_wdata,
    input  logic                          rx_pop,
    output logic [WORD_W-1:0]             rx_rdata,
    output logic [$clog2(DEPTH):0]        rx_level,
    output logic                          rx_full,
    output logic                          rx_empty,
    output logic                          rx_ovf,
    output logic                          rx_unf
);
    localparam int LANES = WORD_W / 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = AW + 1;
    localparam int WLW   = $clog2(WORD_W + 1);
    localparam int NBW   = $clog2(LANES + 1);
    localparam int HALF  = DEPTH / 2;

    fifo_mode_e      mode_q;
    logic            clear, split_mode;
    logic [LW-1:0]   tx_cap, rx_cap;
    logic [AW-1:0]   rx_base;
    logic [NBW-1:0]  nbytes;
    logic [WLW+1:0]  nb_ext;
    logic [7:0]      mem [DEPTH];

    logic [LANES-1:0][AW-1:0] tx_rd_addr, tx_wr_addr, rx_rd_addr, rx_wr_addr;
    logic [LANES-1:0]         tx_wr_en, rx_wr_en;
    logic [LANES-1:0][7:0]    tx_wr_byte, rx_wr_byte, tx_rd_bytes, rx_rd_bytes;

    spi_fifo_mode #(.DEPTH(DEPTH)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_ena (tx_ena),
        .rx_ena (rx_ena),
        .reinit (reinit),
        .mode_q (mode_q),
        .clear  (clear),
        .tx_cap (tx_cap),
        .rx_cap (rx_cap)
    );

    assign split_mode = (mode_q == MODE_SPLIT);
    assign rx_base    = split_mode ? AW'(HALF) : '0;

    // bytes per word: ceil(word_len / 8), limited to the lane count
    always_comb begin
        nb_ext = ((WLW+2)'(word_len) + (WLW+2)'(7)) >> 3;
        if (nb_ext > (WLW+2)'(LANES)) nb_ext = (WLW+2)'(LANES);
        nbytes = NBW'(nb_ext);
    end

    spi_fifo_side #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .cap      (tx_cap),
        .base     ('0),
        .nbytes   (nbytes),
        .push     (tx_push),
        .wdata    (tx_wdata),
        .pop      (tx_pop),
        .rd_bytes (tx_rd_bytes),
        .rd_addr  (tx_rd_addr),
        .wr_en    (tx_wr_en),
        .wr_addr  (tx_wr_addr),
        .wr_byte  (tx_wr_byte),
        .level    (tx_level),
        .rdata    (tx_rdata),
        .ovf      (tx_ovf),
        .unf      (tx_unf)
    );

    spi_fifo_side #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .cap      (rx_cap),
        .base     (rx_base),
        .nbytes   (nbytes),
        .push     (rx_push),
        .wdata    (rx_wdata),
        .pop      (rx_pop),
        .rd_bytes (rx_rd_bytes),
        .rd_addr  (rx_rd_addr),
        .wr_en    (rx_wr_en),
        .wr_addr  (rx_wr_addr),
        .wr_byte  (rx_wr_byte),
        .level    (rx_level),
        .rdata    (rx_rdata),
        .ovf      (rx_ovf),
        .unf      (rx_unf)
    );

    // shared byte pool: the two sides never own the same address
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (tx_wr_en[i]) mem[tx_wr_addr[i]] <= tx_wr_byte[i];
            if (rx_wr_en[i]) mem[rx_wr_addr[i]] <= rx_wr_byte[i];
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            tx_rd_bytes[i] = mem[tx_rd_addr[i]];
            rx_rd_bytes[i] = mem[rx_rd_addr[i]];
        end
    end

    assign tx_full  = (tx_level >= tx_cap);
    assign tx_empty = (tx_level == '0);
    assign rx_full  = (rx_level >= rx_cap);
    assign rx_empty = (rx_level == '0);
endmodule

// File: rtl/spi_byte_fifo_chk.sv
module spi_byte_fifo_chk #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tx_ena,
    input logic                   rx_ena,
    input logic                   split_mode,
    input logic                   tx_push,
    input logic                   tx_pop,
    input logic                   rx_push,
    input logic                   rx_pop,
    input logic                   tx_ovf,
    input logic                   tx_unf,
    input logic                   rx_ovf,
    input logic                   rx_unf,
    input logic [$clog2(DEPTH):0] tx_level,
    input logic [$clog2(DEPTH):0] rx_level,
    input logic [WORD_W-1:0]      tx_rdata,
    input logic [WORD_W-1:0]      rx_rdata
);
    localparam int HALF = DEPTH / 2;

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

    assert_tx_off_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_ena) |-> (tx_level == '0));

    assert_rx_off_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rx_ena) |-> (rx_level == '0));

    assert_split_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        split_mode |-> ((int'(tx_level) <= HALF) && (int'(rx_level) <= HALF)));

    assert_tx_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !$past(tx_pop)) |-> (tx_level == $past(tx_level)));

    assert_rx_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !$past(rx_pop)) |-> (rx_level == $past(rx_level)));

    assert_tx_unf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unf |-> ($stable(tx_rdata) && ($past(tx_push) || $stable(tx_level))));

    assert_rx_unf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unf |-> ($stable(rx_rdata) && ($past(rx_push) || $stable(rx_level))));
endmodule

bind spi_byte_fifo spi_byte_fifo_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ena     (tx_ena),
    .rx_ena     (rx_ena),
    .split_mode (split_mode),
    .tx_push    (tx_push),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .tx_ovf     (tx_ovf),
    .tx_unf     (tx_unf),
    .rx_ovf     (rx_ovf),
    .rx_unf     (rx_unf),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_rdata   (tx_rdata),
    .rx_rdata   (rx_rdata)
);

// File: tb/tb_spi_byte_fifo.sv
`timescale 1ns/1ps
module tb_spi_byte_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_ena = 1'b0, rx_ena = 1'b0, reinit = 1'b0;
    logic [5:0]  word_len = 6'd32;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata;
    logic [6:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, tx_ovf, tx_unf;
    logic        rx_full, rx_empty, rx_ovf, rx_unf;

    int tests = 0;
    int fails = 0;

    logic [7:0]  mq [2][$];
    int          capm [2];
    logic [31:0] last_rd [2];
    logic [32:0] pend_v [$];
    string       pend_t [$];

    always #4 clk = ~clk;

    spi_byte_fifo dut (
        .clk(clk), .rst_n(rst_n), .tx_ena(tx_ena), .rx_ena(rx_ena), .reinit(reinit),
        .word_len(word_len),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf)
    );

    task automatic chk(input string r, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", r, what, got, exp);
        end
    endtask

    // scoreboard monitor: compares each popped word one edge after its request
    always @(posedge clk) begin
        if (pend_v.size() > 0) begin
            logic [32:0] ent;
            string tg;
            ent = pend_v.pop_front();
            tg  = pend_t.pop_front();
            #3;
            chk(tg, ent[32] ? "rx read data" : "tx read data",
                ent[32] ? rx_rdata : tx_rdata, ent[31:0]);
        end
    end

    // byte-level model of one side for one request cycle
    task automatic model_step(input int s, input bit pu, input bit po, input logic [31:0] wd,
                              input int wl, input string r, output bit eo, output bit eu);
        int nb, old, take, store;
        logic [31:0] w;
        nb    = (wl + 7) / 8;
        old   = mq[s].size();
        eo    = pu && (old >= capm[s]);
        eu    = po && (old == 0);
        take  = (po && old > 0) ? ((nb < old) ? nb : old) : 0;
        store = (pu && old < capm[s]) ? ((nb < capm[s] - old) ? nb : capm[s] - old) : 0;
        if (po) begin
            if (eu) w = last_rd[s];
            else begin
                w = '0;
                for (int i = 0; i < take; i++) w[8*i +: 8] = mq[s][i];
            end
            last_rd[s] = w;
            pend_v.push_back({s[0], w});
            pend_t.push_back(r);
        end
        for (int i = 0; i < take; i++) void'(mq[s].pop_front());
        for (int i = 0; i < store; i++) mq[s].push_back(wd[8*i +: 8]);
    endtask

    task automatic op(input bit tpu, input bit tpo, input bit rpu, input bit rpo,
                      input logic [31:0] tw, input logic [31:0] rw, input int wl, input string r);
        bit eo0, eu0, eo1, eu1;
        @(negedge clk);
        tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
        tx_wdata = tw; rx_wdata = rw; word_len = 6'(wl);
        model_step(0, tpu, tpo, tw, wl, r, eo0, eu0);
        model_step(1, rpu, rpo, rw, wl, r, eo1, eu1);
        @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
        chk(r, "tx level", 32'(tx_level), 32'(mq[0].size()));
        chk(r, "rx level", 32'(rx_level), 32'(mq[1].size()));
        chk(r, "tx full", 32'(tx_full), 32'(mq[0].size() >= capm[0]));
        chk(r, "rx full", 32'(rx_full), 32'(mq[1].size() >= capm[1]));
        chk(r, "tx empty", 32'(tx_empty), 32'(mq[0].size() == 0));
        chk(r, "tx overflow", 32'(tx_ovf), 32'(eo0));
        chk(r, "rx overflow", 32'(rx_ovf), 32'(eo1));
        chk(r, "tx underflow", 32'(tx_unf), 32'(eu0));
        chk(r, "rx underflow", 32'(rx_unf), 32'(eu1));
    endtask

    task automatic set_mode(input bit t, input bit r);
        @(negedge clk);
        tx_ena = t; rx_ena = r;
        @(negedge clk);
        mq[0].delete(); mq[1].delete();
        capm[0] = t ? (r ? 32 : 64) : 0;
        capm[1] = r ? (t ? 32 : 64) : 0;
        chk("R7", "tx level after mode change", 32'(tx_level), 32'd0);
        chk("R7", "rx level after mode change", 32'(rx_level), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        capm[0] = 0; capm[1] = 0; last_rd[0] = '0; last_rd[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "tx level", 32'(tx_level), 0);
        chk("R11", "rx level", 32'(rx_level), 0);
        chk("R11", "tx empty/full", {30'd0, tx_empty, tx_full}, 32'd3);
        chk("R11", "rx empty/full", {30'd0, rx_empty, rx_full}, 32'd3);
        chk("R11", "error pulses", {28'd0, tx_ovf, tx_unf, rx_ovf, rx_unf}, 32'd0);
        chk("R11", "read data", tx_rdata | rx_rdata, 32'd0);

        // R1: transmit owns all 64 bytes, receive has none
        set_mode(1'b1, 1'b0);
        op(0, 0, 1, 0, 0, 32'h11, 32, "R1");
        for (int i = 0; i < 16; i++)
            op(1, 0, 0, 0, 32'h0403_0201 + 32'(i) * 32'h1111_1111, 0, 32, "R1");
        op(1, 0, 0, 0, 32'hDEAD_BEEF, 0, 32, "R9");
        op(1, 0, 0, 0, 32'hCAFE_F00D, 0, 8, "R9");
        // R3: words come back least significant byte first, in order
        for (int i = 0; i < 16; i++) op(0, 1, 0, 0, 0, 0, 32, "R3");
        op(0, 1, 0, 0, 0, 0, 32, "R10");
        op(0, 1, 0, 0, 0, 0, 16, "R10");
        // R3: short word lengths
        op(1, 0, 0, 0, 32'h0000_0ABC, 0, 12, "R3");
        op(1, 0, 0, 0, 32'h0000_0005, 0, 4, "R3");
        op(1, 0, 0, 0, 32'h0012_3456, 0, 24, "R3");
        op(0, 1, 0, 0, 0, 0, 12, "R3");
        op(0, 1, 0, 0, 0, 0, 4, "R3");
        op(0, 1, 0, 0, 0, 0, 24, "R3");
        // R5: pop wider than the data held
        op(1, 0, 0, 0, 32'h0000_00A7, 0, 8, "R5");
        op(0, 1, 0, 0, 0, 0, 32, "R5");
        op(1, 0, 0, 0, 32'h0000_C3B2, 0, 16, "R5");
        op(0, 1, 0, 0, 0, 0, 32, "R5");
        // R4: push wider than the space left
        for (int i = 0; i < 15; i++)
            op(1, 0, 0, 0, 32'hA0B0_C0D0 ^ 32'(i), 0, 32, "R4");
        op(1, 0, 0, 0, 32'h0077_8899, 0, 24, "R4");
        op(1, 0, 0, 0, 32'hDDCC_BBAA, 0, 32, "R4");
        for (int i = 0; i < 17; i++) op(0, 1, 0, 0, 0, 0, 32, "R4");

        // R2: split mode, 32 bytes per side
        set_mode(1'b1, 1'b1);
        for (int i = 0; i < 8; i++)
            op(1, 0, 1, 0, 32'h1000_0000 + 32'(i), 32'h2000_0000 + 32'(i), 32, "R2");
        op(1, 0, 1, 0, 32'hFFFF_FFFF, 32'hEEEE_EEEE, 32, "R2");
        for (int i = 0; i < 8; i++) op(0, 1, 0, 1, 0, 0, 32, "R2");
        // R6 and R8: 24-bit stream through each half, wrapping several times
        for (int i = 0; i < 3; i++)
            op(1, 0, 1, 0, 32'(i) * 32'h0003_0507, 32'h00F0_0000 | 32'(i), 24, "R6");
        for (int i = 0; i < 20; i++)
            op(1, 1, 1, 1, 32'h0055_0000 | 32'(i * 7), 32'h00AA_0000 | 32'(i * 13), 24, "R6");
        for (int i = 0; i < 4; i++) op(0, 1, 0, 1, 0, 0, 24, "R6");
        // R8: simultaneous push and pop with one byte held, net +3
        op(1, 0, 0, 0, 32'h0000_005A, 0, 8, "R8");
        op(1, 1, 0, 0, 32'h4433_2211, 0, 32, "R8");
        // R8: simultaneous pop and push on a full side
        for (int i = 0; i < 7; i++) op(1, 0, 0, 0, 32'h0BAD_0000 | 32'(i), 0, 32, "R8");
        op(1, 1, 0, 0, 32'h9999_9999, 0, 32, "R8");

        // R7: reinit clears both sides and drops a push in the same cycle
        op(0, 0, 1, 0, 0, 32'h7777_6666, 32, "R7");
        @(negedge clk);
        reinit = 1'b1; tx_push = 1'b1; tx_wdata = 32'h1234_5678; word_len = 6'd32;
        @(negedge clk);
        reinit = 1'b0; tx_push = 1'b0;
        mq[0].delete(); mq[1].delete();
        chk("R7", "tx level after reinit", 32'(tx_level), 0);
        chk("R7", "rx level after reinit", 32'(rx_level), 0);
        chk("R7", "no overflow in clear cycle", 32'(tx_ovf), 0);
        op(0, 1, 0, 1, 0, 0, 32, "R7");
        // R7: enable change clears a side holding data
        op(0, 0, 1, 0, 0, 32'h5555_4444, 32, "R7");
        set_mode(1'b1, 1'b0);
        op(0, 0, 1, 0, 0, 32'h3333_2222, 32, "R1");
        op(1, 0, 0, 0, 32'h8765_4321, 0, 32, "R7");
        op(0, 1, 0, 0, 0, 0, 32, "R7");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule